// File: doc/BRIEF.md
# Deep-Sleep Wakeup Interrupt Detector

This block stays powered while the main core is switched off in deep sleep. It watches the interrupt lines and, when an enabled line fires, asks the power manager to bring the core back. It has no registers. Everything it does follows from its input signals. When the core enters sleep with the deep-sleep select bit set, the detector takes a copy of the core's interrupt-enable set and arms. While it is armed, the rest of the core, including its periodic tick timer, may be powered down.

When an enabled line asserts, the detector raises its wake request at once. It also latches the line that fired, so a short pulse is not lost. A fixed restore delay then runs while the core powers up and restores its state. Only after that delay does the detector tell the core that an interrupt is ready for servicing. It clears everything when the core reports that it is running again. A debugger connection turns the detector off completely.

Top module: `dsleep_wake_detector`

## Requirements
- R1: After a synchronous reset, `pwr_down_ok`, `wake_req` and `irq_valid` are 0 and `irq_pending` is all zeros.
- R2: The detector arms (`pwr_down_ok` goes to 1 in the next cycle) only on a cycle where `core_sleeping` rises from 0 to 1 while `deep_sleep_sel` is 1 and `dbg_attached` is 0. A sleep entry with `deep_sleep_sel` at 0 never arms it.
- R3: `irq_enable` is sampled only on the arming cycle. Changes to it while the detector is armed or waking have no effect, and a line whose bit was 0 in the sampled copy never causes a wake.
- R4: While armed, any line with its sampled enable bit at 1 that is high at a clock edge makes `wake_req` 1 from that edge on, and `pwr_down_ok` drops at the same edge.
- R5: `irq_pending` bit i holds 1 from the triggering edge onward for every enabled line i that was high at the trigger or at any later edge before the clear, even if the line has since returned to 0.
- R6: `irq_valid` rises exactly `RESTORE_CYCLES` clock cycles after `wake_req` rises (default 8), and `wake_req` stays 1 throughout.
- R7: While `dbg_attached` is 1, the outputs `pwr_down_ok`, `wake_req`, `irq_valid` and `irq_pending` are all cleared at the next edge, and no arming takes place.
- R8: `core_running` at 1 in any non-idle state returns the detector to idle at the next edge, with `wake_req`, `irq_valid`, `pwr_down_ok` and `irq_pending` cleared.
- R9: When the detector is not armed, activity on the interrupt lines has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_IRQ | Interrupt request lines, active high |
| irq_enable | input | N_IRQ | Core's interrupt-enable set, sampled at deep-sleep entry |
| deep_sleep_sel | input | 1 | Deep-sleep select bit from the core |
| core_sleeping | input | 1 | Core sleep indication; a rising edge marks sleep entry |
| core_running | input | 1 | Core reports that it has been restored and is running |
| dbg_attached | input | 1 | A debugger is connected; disables the detector |
| pwr_down_ok | output | 1 | Detector armed; the core may be powered down |
| wake_req | output | 1 | Wake request to the power manager |
| irq_valid | output | 1 | Restore delay finished; latched interrupt may be serviced |
| irq_pending | output | N_IRQ | Latched interrupt lines that caused or joined the wake |

## Verification
A stale copy of the enable set or a wrong pending latch shows on `irq_pending` and `wake_req` in the cycle just after the offending interrupt edge. A miscounted restore timer moves the rising edge of `irq_valid` by one or more cycles from its expected place, `RESTORE_CYCLES` after the wake. A state machine that misses the debugger or resume inputs leaves `wake_req` or `pwr_down_ok` high one cycle after they should have dropped. Because every output is compared against a reference model on every clock, each of these faults shows up at the first cycle where it diverges.

// File: rtl/dswd_pkg.sv
package dswd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RESTORE = 2'd2,
        ST_READY   = 2'd3
    } dswd_state_e;

    typedef struct packed {
        logic kill;    // debugger present
        logic entry;   // qualified deep-sleep entry
        logic hit;     // enabled interrupt seen
        logic resume;  // core reports it is running
        logic done;    // restore delay elapsed
    } dswd_evt_t;

    function automatic dswd_state_e dswd_next(input dswd_state_e cur, input dswd_evt_t ev);
        dswd_state_e nxt;
        nxt = cur;
        if (ev.kill) begin
            nxt = ST_IDLE;
        end else begin
            unique case (cur)
                ST_IDLE:    nxt = ev.entry  ? ST_ARMED : ST_IDLE;
                ST_ARMED:   nxt = ev.resume ? ST_IDLE :
                                  (ev.hit ? ST_RESTORE : ST_ARMED);
                ST_RESTORE: nxt = ev.resume ? ST_IDLE :
                                  (ev.done ? ST_READY : ST_RESTORE);
                ST_READY:   nxt = ev.resume ? ST_IDLE : ST_READY;
                default:    nxt = ST_IDLE;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic dswd_is_waking(input dswd_state_e s);
        return (s == ST_RESTORE) || (s == ST_READY);
    endfunction

endpackage

// File: rtl/dswd_entry_detect.sv
module dswd_entry_detect (
    input  logic clk,
    input  logic rst,
    input  logic core_sleeping,
    input  logic deep_sleep_sel,
    input  logic dbg_attached,
    output logic entry
);
    logic sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= core_sleeping;
        end
    end

    assign entry = core_sleeping && !sleep_q && deep_sleep_sel && !dbg_attached;
endmodule

// File: rtl/dswd_irq_capture.sv
module dswd_irq_capture #(
    parameter int N_IRQ = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             clear,
    input  logic             load,
    input  logic             accum,
    input  logic [N_IRQ-1:0] irq_lines,
    input  logic [N_IRQ-1:0] irq_enable,
    output logic             hit,
    output logic [N_IRQ-1:0] pending
);
    logic [N_IRQ-1:0] en_q;
    logic [N_IRQ-1:0] masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (capture) begin
            en_q <= irq_enable;
        end
    end

    assign masked = irq_lines & en_q;
    assign hit    = |masked;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                pending[i] <= 1'b0;
            end else if (load && hit) begin
                pending[i] <= masked[i];
            end else if (accum && masked[i]) begin
                pending[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dswd_restore_timer.sv
module dswd_restore_timer #(
    parameter int RESTORE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (RESTORE_CYCLES > 1) ? $clog2(RESTORE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RESTORE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/dsleep_wake_detector.sv
module dsleep_wake_detector
    import dswd_pkg::*;
#(
    parameter int N_IRQ          = 16,
    parameter int RESTORE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_lines,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic             deep_sleep_sel,
    input  logic             core_sleeping,
    input  logic             core_running,
    input  logic             dbg_attached,
    output logic             pwr_down_ok,
    output logic             wake_req,
    output logic             irq_valid,
    output logic [N_IRQ-1:0] irq_pending
);
    dswd_state_e state_q;
    dswd_state_e state_d;
    dswd_evt_t   ev;
    logic        entry;
    logic        hit;
    logic        done;
    logic        clear;

    dswd_entry_detect u_entry (
        .clk            (clk),
        .rst            (rst),
        .core_sleeping  (core_sleeping),
        .deep_sleep_sel (deep_sleep_sel),
        .dbg_attached   (dbg_attached),
        .entry          (entry)
    );

    assign clear = dbg_attached || ((state_q != ST_IDLE) && core_running);

    dswd_irq_capture #(.N_IRQ(N_IRQ)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .capture    (entry && (state_q == ST_IDLE)),
        .clear      (clear),
        .load       (state_q == ST_ARMED),
        .accum      (dswd_is_waking(state_q)),
        .irq_lines  (irq_lines),
        .irq_enable (irq_enable),
        .hit        (hit),
        .pending    (irq_pending)
    );

    dswd_restore_timer #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_RESTORE),
        .done (done)
    );

    always_comb begin
        ev.kill   = dbg_attached;
        ev.entry  = entry;
        ev.hit    = hit;
        ev.resume = core_running;
        ev.done   = done;
        state_d   = dswd_next(state_q, ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwr_down_ok = (state_q == ST_ARMED);
    assign wake_req    = dswd_is_waking(state_q);
    assign irq_valid   = (state_q == ST_READY);
endmodule

// File: rtl/dsleep_wake_detector_chk.sv
module dsleep_wake_detector_chk #(
    parameter int N_IRQ          = 16,
    parameter int RESTORE_CYCLES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             deep_sleep_sel,
    input logic             core_sleeping,
    input logic             core_running,
    input logic             dbg_attached,
    input logic             pwr_down_ok,
    input logic             wake_req,
    input logic             irq_valid,
    input logic [N_IRQ-1:0] irq_pending
);
    int unsigned wake_len;

    always_ff @(posedge clk) begin
        if (rst || !wake_req) begin
            wake_len <= 0;
        end else if (!irq_valid) begin
            wake_len <= wake_len + 1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pwr_down_ok && !wake_req && !irq_valid && irq_pending == '0));

    a_r2_arm_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down_ok) |-> ($past(deep_sleep_sel) && $past(core_sleeping) && !$past(dbg_attached)));

    a_r4_wake_from_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> ($past(pwr_down_ok) && !pwr_down_ok));

    a_r5_pending_present: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (irq_pending != '0));

    a_r5_pending_kept: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !core_running && !dbg_attached) |=> ((irq_pending & $past(irq_pending)) == $past(irq_pending)));

    a_r6_restore_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_valid) |-> (wake_len == RESTORE_CYCLES));

    a_r6_valid_under_wake: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> wake_req);

    a_r7_debug_silences: assert property (@(posedge clk) disable iff (rst)
        dbg_attached |=> (!pwr_down_ok && !wake_req && !irq_valid && irq_pending == '0));

    a_r8_resume_clears: assert property (@(posedge clk) disable iff (rst)
        ((wake_req || pwr_down_ok) && core_running) |=> (!wake_req && !pwr_down_ok && irq_pending == '0));
endmodule

bind dsleep_wake_detector dsleep_wake_detector_chk #(
    .N_IRQ          (N_IRQ),
    .RESTORE_CYCLES (RESTORE_CYCLES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .deep_sleep_sel (deep_sleep_sel),
    .core_sleeping  (core_sleeping),
    .core_running   (core_running),
    .dbg_attached   (dbg_attached),
    .pwr_down_ok    (pwr_down_ok),
    .wake_req       (wake_req),
    .irq_valid      (irq_valid),
    .irq_pending    (irq_pending)
);

// File: tb/dsleep_wake_detector_test.sv
`timescale 1ns/1ps
module dsleep_wake_detector_test;
    localparam int N   = 16;
    localparam int RST = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq = '0;
    logic [N-1:0] en  = '0;
    logic         dsel = 1'b0;
    logic         slp  = 1'b0;
    logic         run  = 1'b0;
    logic         dbg  = 1'b0;
    logic         ok_o, wake_o, valid_o;
    logic [N-1:0] pend_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dsleep_wake_detector #(.N_IRQ(N), .RESTORE_CYCLES(RST)) uut (
        .clk(clk), .rst(rst), .irq_lines(irq), .irq_enable(en),
        .deep_sleep_sel(dsel), .core_sleeping(slp), .core_running(run),
        .dbg_attached(dbg), .pwr_down_ok(ok_o), .wake_req(wake_o),
        .irq_valid(valid_o), .irq_pending(pend_o)
    );

    // Behavioural reference: 0 idle, 1 armed, 2 restoring, 3 ready
    int       m_st = 0;
    int       m_cnt = 0;
    bit       m_prev = 0;
    bit       m_live = 0;
    bit [N-1:0] m_mask = '0;
    bit [N-1:0] m_pend = '0;

    always @(posedge clk) begin
        bit [N-1:0] h;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_prev = 0; m_mask = '0; m_pend = '0;
        end else begin
            h = irq & m_mask;
            if (dbg) begin
                m_st = 0; m_pend = '0; m_cnt = 0;
            end else if (m_st != 0 && run) begin
                m_st = 0; m_pend = '0; m_cnt = 0;
            end else begin
                case (m_st)
                    0: if (slp && !m_prev && dsel) begin m_st = 1; m_mask = en; end
                    1: if (h != '0) begin m_pend = h; m_st = 2; m_cnt = 0; end
                    2: begin
                        m_pend = m_pend | h;
                        if (m_cnt == RST - 1) m_st = 3; else m_cnt = m_cnt + 1;
                    end
                    default: m_pend = m_pend | h;
                endcase
            end
            m_prev = slp;
        end
        m_live = 1;
    end

    task automatic check(input bit good, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // lockstep compare every cycle, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (m_live && !finished) begin
            check(ok_o    == (m_st == 1), "R2", "model pwr_down_ok", ok_o, m_st == 1);
            check(wake_o  == (m_st >= 2), "R4", "model wake_req", wake_o, m_st >= 2);
            check(valid_o == (m_st == 3), "R6", "model irq_valid", valid_o, m_st == 3);
            check(pend_o  == m_pend,      "R5", "model irq_pending", pend_o, m_pend);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm(input logic [N-1:0] mask);
        en = mask; dsel = 1'b1; slp = 1'b1;
        tick();
    endtask

    task automatic wake_up();
        run = 1'b1; slp = 1'b0;
        tick();
        run = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int t0;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        check(!ok_o && !wake_o && !valid_o && pend_o == '0, "R1", "reset outputs",
              {ok_o, wake_o, valid_o}, 0);

        // R9 idle: lines toggle, nothing happens
        irq = 16'hFFFF; tick(2); irq = '0; tick();
        check(!wake_o && pend_o == '0, "R9", "idle irq ignored", wake_o, 0);

        // R2 normal sleep (deep select 0) never arms
        en = 16'hFFFF; dsel = 1'b0; slp = 1'b1; tick();
        irq = 16'h0001; tick(2); irq = '0; tick();
        check(!ok_o && !wake_o, "R2", "shallow sleep not armed", {ok_o, wake_o}, 0);
        slp = 1'b0; tick();

        // R2/R3 deep sleep arms and captures mask
        arm(16'h00F0);
        check(ok_o == 1'b1, "R2", "armed after deep entry", ok_o, 1);
        en = 16'hFFFF;
        irq = 16'h0002; tick(); irq = '0; tick();
        check(!wake_o && ok_o, "R3", "later enable change ignored", wake_o, 0);

        // R4/R5 one-cycle pulse on enabled line 5
        irq = 16'h0020; tick(); irq = '0;
        t0 = cyc;
        check(wake_o && !ok_o, "R4", "wake after enabled line", wake_o, 1);
        check(pend_o == 16'h0020, "R5", "pending holds trigger", pend_o, 16'h0020);
        irq = 16'h0041; tick(); irq = '0;
        check(pend_o == 16'h0060, "R5", "pending joins line 6 only", pend_o, 16'h0060);
        check(!valid_o, "R6", "not valid during restore", valid_o, 0);
        while (!valid_o && cyc - t0 < 50) tick();
        check(cyc - t0 == RST, "R6", "restore delay length", cyc - t0, RST);
        check(wake_o && pend_o == 16'h0060, "R5", "pending at service", pend_o, 16'h0060);
        wake_up();
        check(!wake_o && !valid_o && pend_o == '0, "R8", "resume clears", pend_o, 0);

        // R5 multiple lines at trigger
        arm(16'h0F0F);
        irq = 16'h0303; tick(); irq = '0;
        check(pend_o == 16'h0303, "R5", "multi-line trigger", pend_o, 16'h0303);
        // R7 debugger during restore
        tick(3);
        dbg = 1'b1; tick();
        check(!wake_o && !valid_o && !ok_o && pend_o == '0, "R7", "debugger clears wake",
              {wake_o, pend_o}, 0);
        slp = 1'b0; tick();

        // R7 entry with debugger attached does not arm
        slp = 1'b1; tick();
        check(!ok_o, "R7", "no arm with debugger", ok_o, 0);
        irq = 16'h0F0F; tick(); irq = '0; tick();
        check(!wake_o && pend_o == '0, "R7", "no wake with debugger", wake_o, 0);
        dbg = 1'b0; tick(2);
        check(!ok_o, "R2", "held sleep is no entry", ok_o, 0);
        slp = 1'b0; tick();

        // R8 resume while armed without an interrupt
        arm(16'h8000);
        check(ok_o, "R2", "re-armed", ok_o, 1);
        wake_up();
        check(!ok_o && !wake_o, "R8", "resume disarms", ok_o, 0);
        irq = 16'h8000; tick(); irq = '0; tick();
        check(!wake_o, "R9", "line after disarm ignored", wake_o, 0);

        // R4 highest line, then resume during restore
        arm(16'h8000);
        irq = 16'h8000; tick(); irq = '0;
        check(wake_o && pend_o == 16'h8000, "R4", "top line wakes", pend_o, 16'h8000);
        tick(2);
        wake_up();
        check(!wake_o && pend_o == '0, "R8", "resume in restore", wake_o, 0);

        // R1 reset in the middle of a wake
        arm(16'h0001);
        irq = 16'h0001; tick(); irq = '0;
        rst = 1'b1; tick(); rst = 1'b0; slp = 1'b0; tick();
        check(!wake_o && !ok_o && pend_o == '0, "R1", "reset mid-wake", wake_o, 0);

        finish_run();
    end
endmodule